// File: doc/BRIEF.md
# SDRAM Bank-State Protocol Checker

This block is a passive observer for the command side of a two-bank synchronous DRAM bus. It decodes the chip-select, row strobe, column strobe, write enable, clock-enable and address lines on every rising clock edge. It keeps a model of each bank's condition: idle, open with a row, or closing. It also runs the lockout timers that follow a precharge, a refresh and a mode load. It never drives the bus and holds no data.

When a command breaks a rule, the checker latches an error flag and a small code that names the rule. The first violation wins, and the record stays until a clear input is pulsed. It is meant to sit beside a memory controller in simulation. It is also synthesizable, so it can stay in a design as checking logic. Commands that break a rule are not applied to the bank model or to the timers.

Top module: `sdram_cmd_checker`

## Requirements
- R1: A command is decoded only when `cs_n` is low and `cke` was high in the previous cycle; the `cke` history resets to high. With `cs_n` low the pins {ras_n,cas_n,we_n} encode: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode load. Codes 111 (no-op) and 110 (burst stop) are not checked and change nothing.
- R2: Address bit 11 selects the bank. An activate to an idle bank makes `bank_state` show open (1) after that edge. An activate to a bank that is already open records code 7.
- R3: A read or write to a bank that is not open records code 4.
- R4: A precharge with address bit 10 low closes the selected bank. With bit 10 high it closes both banks, including idle ones. A bank shows closing (2) for T_RP-1 cycles after the command and idle (0) from cycle T_RP on. Any command aimed at a closing bank records code 3; refresh, mode load and precharge-all are aimed at every bank.
- R5: A read or write with address bit 10 high keeps the bank open for BL cycles (command cycle included). An internal precharge then follows in the last burst cycle: the bank shows closing from cycle BL after the command and idle from cycle BL-1+T_RP.
- R6: A mode load while any bank is open records code 5. Address bits 2:0 give the burst length: 0→1, 1→2, 2→4, 3→8. Any other value records code 8 and leaves the stored length unchanged. The length after reset is 1.
- R7: A refresh while any bank is open records code 6.
- R8: Any command in the T_RC-1 cycles after a refresh records code 1. Any command in the T_MCD-1 cycles after a mode load records code 2.
- R9: Precedence: code 1, then 2, then 3, then the rule-specific codes, with code 5 ahead of code 8. A command that records a code changes no bank state and starts no window.
- R10: `err_flag` and `err_code` are set by the edge that samples the first violation. Later violations leave them unchanged. `clr_err` clears both to 0 at the next edge, and a violation in the clearing cycle is dropped.
- R11: After reset both banks are idle, `err_flag` is 0 and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr_err | input | 1 | Clears the latched error record |
| cke | input | 1 | Observed clock enable |
| cs_n | input | 1 | Observed chip select, active low |
| ras_n | input | 1 | Observed row strobe, active low |
| cas_n | input | 1 | Observed column strobe, active low |
| we_n | input | 1 | Observed write enable, active low |
| addr | input | ADDR_W | Observed address; bit 11 bank, bit 10 auto/all, bits 2:0 burst code |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first violation |
| bank_state | output | 2*2 | Per-bank state, bank b at bits 2b+1:2b (0 idle, 1 open, 2 closing) |

## Verification
Some properties hold on every cycle, and the embedded assertions check those. A closing bank never jumps straight back to open. A legal activate always opens its bank, and a precharge always enters closing. The error record never changes while it is set and not being cleared. No bank leaves idle in the two cycles after a legal refresh. The bench scenarios cover what only concrete sequences can show: the exact cycle a bank closes after auto-precharge with burst lengths 1, 4 and 8, the precedence between competing codes, that an illegal mode load does not change the stored length, and that deselected commands and commands following a low clock enable are ignored.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  localparam int BANKS     = 2;
  localparam int MODE_W    = 3;
  localparam int BL_CODE_MAX = 3;
  localparam int BLEN_W    = BL_CODE_MAX + 2;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_CLOSING = 2'd2
  } bank_st_e;

  typedef enum logic [3:0] {
    VIO_NONE         = 4'd0,
    VIO_REF_WIN      = 4'd1,
    VIO_MODE_WIN     = 4'd2,
    VIO_PRE_WIN      = 4'd3,
    VIO_NOT_OPEN     = 4'd4,
    VIO_MODE_BUSY    = 4'd5,
    VIO_REF_BUSY     = 4'd6,
    VIO_ALREADY_OPEN = 4'd7,
    VIO_BAD_BURST    = 4'd8
  } vio_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_chk_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output cmd_e              cmd,
  output logic              bank_sel,
  output logic              ap_flag,
  output logic [MODE_W-1:0] mode_bl
);

  localparam int BANK_BIT = ADDR_W - 1;
  localparam int AP_BIT   = ADDR_W - 2;

  logic cke_q;
  logic unused_addr_bits;

  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b1;
    else     cke_q <= cke;
  end

  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n && cke_q) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign bank_sel = addr[BANK_BIT];
  assign ap_flag  = addr[AP_BIT];
  assign mode_bl  = addr[MODE_W-1:0];
  assign unused_addr_bits = ^addr[AP_BIT-1:MODE_W];

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_chk_pkg::*;
#(
  parameter int T_RP = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_go,
  input  logic              pre_go,
  input  logic              ap_go,
  input  logic [BLEN_W-1:0] burst_len,
  output bank_st_e          state
);

  localparam int RP_W = (T_RP > 2) ? $clog2(T_RP) : 1;

  logic [RP_W-1:0]   rp_cnt;
  logic              ap_arm;
  logic [BLEN_W-1:0] ap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= BK_IDLE;
      rp_cnt <= '0;
      ap_arm <= 1'b0;
      ap_cnt <= '0;
    end else if (pre_go) begin
      state  <= BK_CLOSING;
      rp_cnt <= RP_W'(T_RP - 2);
      ap_arm <= 1'b0;
    end else if (act_go) begin
      state <= BK_OPEN;
    end else if (ap_go) begin
      if (burst_len == BLEN_W'(1)) begin
        state  <= BK_CLOSING;
        rp_cnt <= RP_W'(T_RP - 2);
      end else begin
        ap_arm <= 1'b1;
        ap_cnt <= burst_len - BLEN_W'(2);
      end
    end else begin
      if (state == BK_CLOSING) begin
        if (rp_cnt == '0) state <= BK_IDLE;
        else              rp_cnt <= rp_cnt - 1'b1;
      end
      if (ap_arm) begin
        if (ap_cnt == '0) begin
          state  <= BK_CLOSING;
          rp_cnt <= RP_W'(T_RP - 2);
          ap_arm <= 1'b0;
        end else begin
          ap_cnt <= ap_cnt - 1'b1;
        end
      end
    end
  end

  // R4
  closing_no_reopen_chk: assert property (@(posedge clk) disable iff (rst)
    (state == BK_CLOSING) |=> (state != BK_OPEN));

  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (rst)
    (act_go && !pre_go) |=> (state == BK_OPEN));

  // R4
  pre_closes_chk: assert property (@(posedge clk) disable iff (rst)
    pre_go |=> (state == BK_CLOSING));

endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_chk_pkg::*;
#(
  parameter int T_RC  = 6,
  parameter int T_MCD = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_err,
  input  cmd_e              cmd,
  input  logic              bank_sel,
  input  logic              ap_flag,
  input  logic [MODE_W-1:0] mode_bl,
  input  logic [BANKS-1:0]  bk_open,
  input  logic [BANKS-1:0]  bk_closing,
  output logic              cmd_legal,
  output logic [BLEN_W-1:0] burst_len,
  output logic              err_flag,
  output vio_e              err_code
);

  localparam int RC_W  = (T_RC  > 2) ? $clog2(T_RC)  : 1;
  localparam int MCD_W = (T_MCD > 2) ? $clog2(T_MCD) : 1;
  localparam int CODE_W = $clog2(BL_CODE_MAX + 1);

  logic [RC_W-1:0]   rc_cnt;
  logic [MCD_W-1:0]  mcd_cnt;
  logic [CODE_W-1:0] bl_code;
  vio_e              vio;
  logic              tgt_open, tgt_closing, any_open, any_closing;

  assign tgt_open    = bk_open[bank_sel];
  assign tgt_closing = bk_closing[bank_sel];
  assign any_open    = |bk_open;
  assign any_closing = |bk_closing;

  always_comb begin
    vio = VIO_NONE;
    if (cmd != CMD_NOP) begin
      if (rc_cnt != '0)       vio = VIO_REF_WIN;
      else if (mcd_cnt != '0) vio = VIO_MODE_WIN;
      else begin
        unique case (cmd)
          CMD_ACT: begin
            if (tgt_closing)   vio = VIO_PRE_WIN;
            else if (tgt_open) vio = VIO_ALREADY_OPEN;
          end
          CMD_RD, CMD_WR: begin
            if (tgt_closing)    vio = VIO_PRE_WIN;
            else if (!tgt_open) vio = VIO_NOT_OPEN;
          end
          CMD_PRE: begin
            if (ap_flag ? any_closing : tgt_closing) vio = VIO_PRE_WIN;
          end
          CMD_REF: begin
            if (any_closing)   vio = VIO_PRE_WIN;
            else if (any_open) vio = VIO_REF_BUSY;
          end
          CMD_MRS: begin
            if (any_closing)   vio = VIO_PRE_WIN;
            else if (any_open) vio = VIO_MODE_BUSY;
            else if (mode_bl > MODE_W'(BL_CODE_MAX)) vio = VIO_BAD_BURST;
          end
          default: vio = VIO_NONE;
        endcase
      end
    end
  end

  assign cmd_legal = (cmd != CMD_NOP) && (vio == VIO_NONE);
  assign burst_len = BLEN_W'(1) << bl_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      rc_cnt  <= '0;
      mcd_cnt <= '0;
      bl_code <= '0;
    end else begin
      if (cmd_legal && cmd == CMD_REF) rc_cnt <= RC_W'(T_RC - 1);
      else if (rc_cnt != '0)           rc_cnt <= rc_cnt - 1'b1;
      if (cmd_legal && cmd == CMD_MRS) begin
        mcd_cnt <= MCD_W'(T_MCD - 1);
        bl_code <= mode_bl[CODE_W-1:0];
      end else if (mcd_cnt != '0) begin
        mcd_cnt <= mcd_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_err) begin
      err_flag <= 1'b0;
      err_code <= VIO_NONE;
    end else if (!err_flag && vio != VIO_NONE) begin
      err_flag <= 1'b1;
      err_code <= vio;
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !clr_err) |=> (err_flag && $stable(err_code)));

  // R10
  err_code_named_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (err_code != VIO_NONE));

  // R8
  ref_window_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF && cmd_legal) |=> ##1 (bk_open == '0));

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int T_RP   = 3,
  parameter int T_RC   = 6,
  parameter int T_MCD  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_err,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 err_flag,
  output logic [3:0]           err_code,
  output logic [2*BANKS-1:0]   bank_state
);

  cmd_e              cmd;
  logic              bank_sel, ap_flag, cmd_legal;
  logic [MODE_W-1:0] mode_bl;
  logic [BLEN_W-1:0] burst_len;
  logic [BANKS-1:0]  bk_open, bk_closing;
  vio_e              code_q;

  sdram_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .cmd(cmd),
    .bank_sel(bank_sel), .ap_flag(ap_flag), .mode_bl(mode_bl)
  );

  sdram_rule_check #(.T_RC(T_RC), .T_MCD(T_MCD)) u_rules (
    .clk(clk), .rst(rst), .clr_err(clr_err), .cmd(cmd),
    .bank_sel(bank_sel), .ap_flag(ap_flag), .mode_bl(mode_bl),
    .bk_open(bk_open), .bk_closing(bk_closing), .cmd_legal(cmd_legal),
    .burst_len(burst_len), .err_flag(err_flag), .err_code(code_q)
  );

  assign err_code = code_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic     hit, act_go, pre_go, ap_go;
    bank_st_e st;

    assign hit    = (bank_sel == 1'(b));
    assign act_go = cmd_legal && cmd == CMD_ACT && hit;
    assign pre_go = cmd_legal && cmd == CMD_PRE && (hit || ap_flag);
    assign ap_go  = cmd_legal && (cmd == CMD_RD || cmd == CMD_WR) && hit && ap_flag;

    sdram_bank_fsm #(.T_RP(T_RP)) u_fsm (
      .clk(clk), .rst(rst), .act_go(act_go), .pre_go(pre_go),
      .ap_go(ap_go), .burst_len(burst_len), .state(st)
    );

    assign bk_open[b]          = (st == BK_OPEN);
    assign bk_closing[b]       = (st == BK_CLOSING);
    assign bank_state[2*b +: 2] = st;
  end

endmodule

// File: tb/tb_sdram_cmd_checker.sv
module tb_sdram_cmd_checker;

  localparam int AW = 12;
  localparam logic [2:0] OP_NOP = 3'b111, OP_ACT = 3'b011, OP_RD = 3'b101,
                         OP_WR = 3'b100, OP_PRE = 3'b010, OP_REF = 3'b001,
                         OP_MRS = 3'b000, OP_BST = 3'b110;
  localparam logic [1:0] I = 2'd0, A = 2'd1, P = 2'd2;

  logic          clk = 1'b0, rst = 1'b1, clr_err = 1'b0, cke = 1'b1;
  logic          cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          err_flag;
  logic [3:0]    err_code;
  logic [3:0]    bank_state;

  int checks = 0, errors = 0;
  logic  done = 1'b0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  sdram_cmd_checker dut (
    .clk(clk), .rst(rst), .clr_err(clr_err), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
    .err_flag(err_flag), .err_code(err_code), .bank_state(bank_state)
  );

  always #4 clk = ~clk;

  task automatic drive(input logic csn, input logic ck, input logic clr,
                       input logic [2:0] op, input logic bk, input logic a10,
                       input logic [2:0] lo, input logic [1:0] e0,
                       input logic [1:0] e1, input logic ef,
                       input logic [3:0] ec, input string tag);
    @(negedge clk);
    cs_n = csn; cke = ck; clr_err = clr;
    {ras_n, cas_n, we_n} = op;
    addr = '0;
    addr[AW-1] = bk; addr[AW-2] = a10; addr[2:0] = lo;
    exp_q.push_back({e0, e1, ef, ec});
    tag_q.push_back(tag);
  endtask

  task automatic go(input logic [2:0] op, input logic bk, input logic a10,
                    input logic [2:0] lo, input logic [1:0] e0,
                    input logic [1:0] e1, input logic ef,
                    input logic [3:0] ec, input string tag);
    drive(1'b0, 1'b1, 1'b0, op, bk, a10, lo, e0, e1, ef, ec, tag);
  endtask

  task automatic nop(input logic [1:0] e0, input logic [1:0] e1,
                     input logic ef, input logic [3:0] ec, input string tag);
    drive(1'b0, 1'b1, 1'b0, OP_NOP, 1'b0, 1'b0, 3'd0, e0, e1, ef, ec, tag);
  endtask

  task automatic clr(input logic [1:0] e0, input logic [1:0] e1);
    drive(1'b0, 1'b1, 1'b1, OP_NOP, 1'b0, 1'b0, 3'd0, e0, e1, 1'b0, 4'd0,
          "R10 clear");
  endtask

  // monitor: compare one expected item per cycle, after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [8:0] e;
        logic [8:0] got;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = {bank_state[1:0], bank_state[3:2], err_flag, err_code};
        checks++;
        if (got !== e) begin
          errors++;
          $display("FAIL %s: got b0=%0d b1=%0d flag=%0d code=%0d exp b0=%0d b1=%0d flag=%0d code=%0d",
                   t, got[8:7], got[6:5], got[4], got[3:0],
                   e[8:7], e[6:5], e[4], e[3:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nop(I, I, 0, 0, "R11 reset state");
    go(OP_MRS, 0, 0, 3'd2, I, I, 0, 0, "R6 mode load BL4");
    nop(I, I, 0, 0, "R8 no-op inside mode window");
    go(OP_ACT, 0, 0, 0, A, I, 0, 0, "R2 activate bank0");
    go(OP_ACT, 1, 0, 0, A, A, 0, 0, "R2 activate bank1");
    go(OP_RD, 0, 0, 0, A, A, 0, 0, "R3 read open bank");
    go(OP_WR, 1, 1, 0, A, A, 0, 0, "R5 write auto BL4");
    nop(A, A, 0, 0, "R5 burst cycle 2");
    nop(A, A, 0, 0, "R5 burst cycle 3");
    nop(A, P, 0, 0, "R5 closes after BL4");
    go(OP_ACT, 1, 0, 0, A, P, 1, 3, "R4 activate in tRP");
    nop(A, I, 1, 3, "R5 idle after tRP");
    go(OP_RD, 1, 0, 0, A, I, 1, 3, "R10 first code kept");
    clr(A, I);
    drive(1'b0, 1'b1, 1'b1, OP_RD, 1'b1, 1'b0, 3'd0, A, I, 0, 0,
          "R10 clear wins over violation");
    nop(A, I, 0, 0, "R10 violation dropped");
    go(OP_RD, 1, 0, 0, A, I, 1, 4, "R3 read closed bank");
    clr(A, I);
    go(OP_MRS, 0, 0, 3'd1, A, I, 1, 5, "R6 mode load while open");
    clr(A, I);
    go(OP_REF, 0, 0, 0, A, I, 1, 6, "R7 refresh while open");
    clr(A, I);
    go(OP_ACT, 0, 0, 0, A, I, 1, 7, "R2 activate open bank");
    clr(A, I);
    go(OP_MRS, 0, 0, 3'd5, A, I, 1, 5, "R9 busy ahead of bad burst");
    clr(A, I);
    go(OP_PRE, 1, 1, 0, P, P, 0, 0, "R4 precharge all");
    go(OP_RD, 1, 0, 0, P, P, 1, 3, "R9 tRP ahead of not-open");
    nop(I, I, 1, 3, "R4 both idle after tRP");
    clr(I, I);
    go(OP_REF, 0, 0, 0, I, I, 0, 0, "R7 refresh when idle");
    go(OP_BST, 0, 0, 0, I, I, 0, 0, "R1 burst stop ignored");
    go(OP_ACT, 0, 0, 0, I, I, 1, 1, "R8 activate in tRC");
    clr(I, I);
    nop(I, I, 0, 0, "R8 window");
    nop(I, I, 0, 0, "R8 window");
    go(OP_ACT, 0, 0, 0, A, I, 0, 0, "R8 activate after tRC");
    go(OP_PRE, 0, 0, 0, P, I, 0, 0, "R4 single precharge");
    nop(P, I, 0, 0, "R4 closing");
    nop(I, I, 0, 0, "R4 idle at tRP");
    go(OP_MRS, 0, 0, 3'd3, I, I, 0, 0, "R6 mode load BL8");
    go(OP_ACT, 1, 0, 0, I, I, 1, 2, "R8 activate in tMCD");
    clr(I, I);
    go(OP_ACT, 0, 0, 0, A, I, 0, 0, "R2 activate bank0");
    go(OP_RD, 0, 1, 0, A, I, 0, 0, "R5 read auto BL8");
    for (int k = 0; k < 6; k++) nop(A, I, 0, 0, "R5 BL8 burst open");
    nop(P, I, 0, 0, "R5 BL8 closes");
    nop(P, I, 0, 0, "R5 BL8 closing");
    nop(I, I, 0, 0, "R5 BL8 idle");
    go(OP_MRS, 0, 0, 3'd5, I, I, 1, 8, "R6 bad burst code");
    clr(I, I);
    go(OP_ACT, 1, 0, 0, I, A, 0, 0, "R2 activate bank1");
    go(OP_RD, 1, 1, 0, I, A, 0, 0, "R6 length kept after bad load");
    for (int k = 0; k < 6; k++) nop(I, A, 0, 0, "R6 BL8 still in force");
    nop(I, P, 0, 0, "R6 closes at BL8");
    nop(I, P, 0, 0, "R6 closing");
    nop(I, I, 0, 0, "R6 idle");
    go(OP_MRS, 0, 0, 3'd0, I, I, 0, 0, "R6 mode load BL1");
    nop(I, I, 0, 0, "R8 mode window");
    go(OP_ACT, 1, 0, 0, I, A, 0, 0, "R2 activate bank1");
    go(OP_WR, 1, 1, 0, I, P, 0, 0, "R5 BL1 closes at once");
    nop(I, P, 0, 0, "R5 BL1 closing");
    nop(I, I, 0, 0, "R5 BL1 idle");
    drive(1'b1, 1'b1, 1'b0, OP_RD, 1'b1, 1'b0, 3'd0, I, I, 0, 0,
          "R1 deselected read ignored");
    drive(1'b0, 1'b0, 1'b0, OP_NOP, 1'b0, 1'b0, 3'd0, I, I, 0, 0,
          "R1 clock enable low");
    drive(1'b0, 1'b1, 1'b0, OP_RD, 1'b1, 1'b0, 3'd0, I, I, 0, 0,
          "R1 read after low cke ignored");
    go(OP_ACT, 0, 0, 0, A, I, 0, 0, "R1 decode resumes");
    nop(A, I, 0, 0, "R1 settle");
    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule